// File: doc/BRIEF.md
# Prefixed Shift, Rotate and Single-Bit Operation Unit

This unit performs the bit-manipulation instructions that an 8-bit CPU reaches through its prefix byte. It also handles the four short accumulator rotates that sit outside the prefix space. The sequencer supplies four things: the instruction byte that follows the prefix, the 8-bit operand it has already fetched, and the current flag byte. It also raises `acc_mode` when the instruction is one of the accumulator rotates. One clock later the unit returns the new value, the new flags, a write-back enable and the number of machine cycles the instruction occupies. Operand fetch and bus traffic remain with the sequencer.

The instruction byte is split into three fields. Bits 7:6 choose the group: 0 is rotate/shift, 1 is bit test, 2 is bit clear and 3 is bit set. Bits 5:3 choose either the rotate/shift kind or the bit number. Bits 2:0 choose the register, and index 6 stands for the memory byte addressed by the pointer pair. In the flag byte, Z is bit 7, N is bit 6, H is bit 5 and C is bit 4. Bits 3:0 are always output as zero.

Top module: `bitop_unit`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `out_valid`, `result`, `flags_out`, `wr_en` and `cycles` are all zero.
- R2: Each cycle with `in_valid` high produces exactly one `out_valid` pulse in the following cycle. No pulse appears otherwise.
- R3: Group 0 rotates are selected by bits 5:3. Kind 0 is left circular, kind 1 is right circular, kind 2 is left through C (old C enters bit 0) and kind 3 is right through C (old C enters bit 7). C takes the bit that is shifted out.
- R4: Group 0 shifts are selected by bits 5:3. Kind 4 shifts left and fills with 0. Kind 5 shifts right and keeps bit 7. Kind 7 shifts right and fills bit 7 with 0. C takes the bit that is shifted out.
- R5: In prefixed group 0, N and H are cleared and Z is set exactly when the result is zero.
- R6: Group 0 kind 6 swaps the two nibbles. It clears N, H and C and sets Z from the result.
- R7: Group 1 (bit test) sets Z to the inverse of the selected operand bit. It clears N, sets H and passes C through unchanged. `result` equals the operand and `wr_en` is 0.
- R8: Groups 2 and 3 clear or set the selected bit and leave all other bits alone. `flags_out[7:4]` equals `flags_in[7:4]` and `wr_en` is 1.
- R9: With `acc_mode` high, bits 4:3 pick a rotate kind from 0 to 3 with the behaviour of R3. Z is always 0, N and H are 0, `wr_en` is 1 and `cycles` is 1.
- R10: A prefixed instruction with register index 0–5 or 7 takes 2 cycles. Index 6 (memory) takes 4 cycles in every group, bit test included.
- R11: `flags_out[3:0]` is 0 on every result, whatever `flags_in[3:0]` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| acc_mode | input | 1 | 1 = non-prefixed accumulator rotate |
| op_code | input | 8 | Instruction byte after the prefix |
| operand | input | 8 | Operand value |
| flags_in | input | 8 | Current flag byte |
| out_valid | output | 1 | Result strobe, one cycle after request |
| result | output | 8 | New operand value |
| flags_out | output | 8 | New flag byte |
| wr_en | output | 1 | Write the result back to the operand location |
| cycles | output | 3 | Machine cycles taken by the instruction |

## Verification
Every output is produced by a single register stage, so each result appears exactly one clock after the edge that samples `in_valid`. The bench drives a request on a falling edge. The monitor reads the outputs on the next falling edge, which comes half a period after that capture edge. Each request places one expected item in a queue, and each `out_valid` pulse must remove exactly one. A pulse with nothing queued, or an item left in the queue at the end, counts as a failure.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  localparam int DW     = 8;
  localparam int FZ_POS = 7;
  localparam int FN_POS = 6;
  localparam int FH_POS = 5;
  localparam int FC_POS = 4;

  typedef enum logic [1:0] {
    GRP_SHIFT = 2'd0,
    GRP_TEST  = 2'd1,
    GRP_CLR   = 2'd2,
    GRP_SET   = 2'd3
  } grp_e;

  typedef enum logic [2:0] {
    SK_ROL  = 3'd0,
    SK_ROR  = 3'd1,
    SK_RLC  = 3'd2,
    SK_RRC  = 3'd3,
    SK_SHL  = 3'd4,
    SK_ASR  = 3'd5,
    SK_NIB  = 3'd6,
    SK_LSR  = 3'd7
  } shk_e;
endpackage

// File: rtl/bitop_shifter.sv
module bitop_shifter
  import bitop_pkg::*;
#(
  parameter int W = DW
) (
  input  shk_e         kind,
  input  logic [W-1:0] din,
  input  logic         c_in,
  output logic [W-1:0] dout,
  output logic         c_out
);
  localparam int HALF = W / 2;

  always_comb begin
    dout  = din;
    c_out = 1'b0;
    unique case (kind)
      SK_ROL: begin dout = {din[W-2:0], din[W-1]}; c_out = din[W-1]; end
      SK_ROR: begin dout = {din[0], din[W-1:1]};   c_out = din[0];   end
      SK_RLC: begin dout = {din[W-2:0], c_in};     c_out = din[W-1]; end
      SK_RRC: begin dout = {c_in, din[W-1:1]};     c_out = din[0];   end
      SK_SHL: begin dout = {din[W-2:0], 1'b0};     c_out = din[W-1]; end
      SK_ASR: begin dout = {din[W-1], din[W-1:1]}; c_out = din[0];   end
      SK_NIB: begin dout = {din[HALF-1:0], din[W-1:HALF]}; c_out = 1'b0; end
      SK_LSR: begin dout = {1'b0, din[W-1:1]};     c_out = din[0];   end
      default: begin dout = din; c_out = 1'b0; end
    endcase
  end
endmodule

// File: rtl/bitop_bitfield.sv
module bitop_bitfield
  import bitop_pkg::*;
#(
  parameter int W  = DW,
  parameter int IW = $clog2(W)
) (
  input  grp_e          grp,
  input  logic [IW-1:0] idx,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic          sel_bit
);
  logic [W-1:0] mask;

  for (genvar i = 0; i < W; i++) begin : g_mask
    assign mask[i] = (idx == IW'(i));
  end

  assign sel_bit = |(din & mask);

  always_comb begin
    unique case (grp)
      GRP_CLR: dout = din & ~mask;
      GRP_SET: dout = din | mask;
      default: dout = din;
    endcase
  end
endmodule

// File: rtl/bitop_timing.sv
module bitop_timing #(
  parameter int CYC_W      = 3,
  parameter int ACC_CYCLES = 1,
  parameter int REG_CYCLES = 2,
  parameter int MEM_CYCLES = 4,
  parameter int MEM_INDEX  = 6
) (
  input  logic             acc_mode,
  input  logic [2:0]       reg_idx,
  output logic [CYC_W-1:0] cycles
);
  always_comb begin
    if (acc_mode)
      cycles = CYC_W'(ACC_CYCLES);
    else if (reg_idx == 3'(MEM_INDEX))
      cycles = CYC_W'(MEM_CYCLES);
    else
      cycles = CYC_W'(REG_CYCLES);
  end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int W          = DW,
  parameter int CYC_W      = 3,
  parameter int ACC_CYCLES = 1,
  parameter int REG_CYCLES = 2,
  parameter int MEM_CYCLES = 4,
  parameter int MEM_INDEX  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             acc_mode,
  input  logic [7:0]       op_code,
  input  logic [W-1:0]     operand,
  input  logic [7:0]       flags_in,
  output logic             out_valid,
  output logic [W-1:0]     result,
  output logic [7:0]       flags_out,
  output logic             wr_en,
  output logic [CYC_W-1:0] cycles
);
  grp_e            grp;
  shk_e            kind;
  logic [2:0]      mid;
  logic [W-1:0]    sh_val, bf_val, nxt_val;
  logic            sh_c, sel_bit;
  logic [7:0]      nxt_flags;
  logic            nxt_wr;
  logic [CYC_W-1:0] nxt_cyc;

  assign grp  = acc_mode ? GRP_SHIFT : grp_e'(op_code[7:6]);
  assign mid  = acc_mode ? {1'b0, op_code[4:3]} : op_code[5:3];
  assign kind = shk_e'(mid);

  bitop_shifter #(.W(W)) u_shift (
    .kind (kind),
    .din  (operand),
    .c_in (flags_in[FC_POS]),
    .dout (sh_val),
    .c_out(sh_c)
  );

  bitop_bitfield #(.W(W)) u_bits (
    .grp    (grp),
    .idx    (mid[$clog2(W)-1:0]),
    .din    (operand),
    .dout   (bf_val),
    .sel_bit(sel_bit)
  );

  bitop_timing #(
    .CYC_W     (CYC_W),
    .ACC_CYCLES(ACC_CYCLES),
    .REG_CYCLES(REG_CYCLES),
    .MEM_CYCLES(MEM_CYCLES),
    .MEM_INDEX (MEM_INDEX)
  ) u_time (
    .acc_mode(acc_mode),
    .reg_idx (op_code[2:0]),
    .cycles  (nxt_cyc)
  );

  always_comb begin
    nxt_flags = 8'h00;
    nxt_val   = operand;
    nxt_wr    = 1'b1;
    unique case (grp)
      GRP_SHIFT: begin
        nxt_val = sh_val;
        nxt_flags[FZ_POS] = ~acc_mode & (sh_val == '0);
        nxt_flags[FC_POS] = sh_c;
      end
      GRP_TEST: begin
        nxt_wr = 1'b0;
        nxt_flags[FZ_POS] = ~sel_bit;
        nxt_flags[FH_POS] = 1'b1;
        nxt_flags[FC_POS] = flags_in[FC_POS];
      end
      default: begin
        nxt_val = bf_val;
        nxt_flags[7:4] = flags_in[7:4];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      flags_out <= 8'h00;
      wr_en     <= 1'b0;
      cycles    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= nxt_val;
        flags_out <= nxt_flags;
        wr_en     <= nxt_wr;
        cycles    <= nxt_cyc;
      end
    end
  end
endmodule

// File: rtl/bitop_unit_checker.sv
module bitop_unit_checker #(
  parameter int W     = 8,
  parameter int CYC_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             acc_mode,
  input logic [7:0]       op_code,
  input logic [W-1:0]     operand,
  input logic [7:0]       flags_in,
  input logic             out_valid,
  input logic [W-1:0]     result,
  input logic [7:0]       flags_out,
  input logic             wr_en,
  input logic [CYC_W-1:0] cycles
);
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_shift_flags_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !acc_mode && op_code[7:6] == 2'd0) |=>
      (!flags_out[6] && !flags_out[5] && (flags_out[7] == (result == '0))));
  assert_test_nowrite_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !acc_mode && op_code[7:6] == 2'd1) |=>
      (!wr_en && flags_out[5] && !flags_out[6] && flags_out[4] == $past(flags_in[4])
       && result == $past(operand)));
  assert_flags_kept_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !acc_mode && op_code[7]) |=>
      (wr_en && flags_out[7:4] == $past(flags_in[7:4])));
  assert_acc_form_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && acc_mode) |=> (!flags_out[7] && wr_en && cycles == CYC_W'(1)));
  assert_mem_cycles_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !acc_mode && op_code[2:0] == 3'd6) |=> (cycles == CYC_W'(4)));
  assert_low_nibble_R11: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (flags_out[3:0] == 4'h0));
endmodule

bind bitop_unit bitop_unit_checker #(.W(W), .CYC_W(CYC_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .acc_mode(acc_mode),
  .op_code(op_code), .operand(operand), .flags_in(flags_in),
  .out_valid(out_valid), .result(result), .flags_out(flags_out),
  .wr_en(wr_en), .cycles(cycles)
);

// File: tb/bitop_unit_bench.sv
module bitop_unit_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       acc_mode = 1'b0;
  logic [7:0] op_code = 8'h00;
  logic [7:0] operand = 8'h00;
  logic [7:0] flags_in = 8'h00;
  logic       out_valid;
  logic [7:0] result;
  logic [7:0] flags_out;
  logic       wr_en;
  logic [2:0] cycles;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [7:0] val;
    logic [7:0] flg;
    logic       wr;
    logic [2:0] cyc;
    string      tag;
  } exp_t;

  exp_t sb[$];

  always #4 clk = ~clk;

  bitop_unit u_bitop_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .acc_mode(acc_mode),
    .op_code(op_code), .operand(operand), .flags_in(flags_in),
    .out_valid(out_valid), .result(result), .flags_out(flags_out),
    .wr_en(wr_en), .cycles(cycles)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input logic acc, input logic [7:0] op,
                                 input logic [7:0] d, input logic [7:0] f);
    exp_t e;
    logic [2:0] y;
    logic [1:0] g;
    logic c, co;
    logic [7:0] r;
    c  = f[4];
    y  = acc ? {1'b0, op[4:3]} : op[5:3];
    g  = acc ? 2'd0 : op[7:6];
    co = 1'b0;
    r  = d;
    e.wr  = 1'b1;
    e.cyc = acc ? 3'd1 : ((op[2:0] == 3'd6) ? 3'd4 : 3'd2);
    case (g)
      2'd0: begin
        case (y)
          3'd0: begin r = {d[6:0], d[7]}; co = d[7]; end
          3'd1: begin r = {d[0], d[7:1]}; co = d[0]; end
          3'd2: begin r = {d[6:0], c};    co = d[7]; end
          3'd3: begin r = {c, d[7:1]};    co = d[0]; end
          3'd4: begin r = {d[6:0], 1'b0}; co = d[7]; end
          3'd5: begin r = {d[7], d[7:1]}; co = d[0]; end
          3'd6: begin r = {d[3:0], d[7:4]}; co = 1'b0; end
          default: begin r = {1'b0, d[7:1]}; co = d[0]; end
        endcase
        e.flg = {(!acc && r == 8'h00), 1'b0, 1'b0, co, 4'h0};
        e.tag = acc ? "R9" : (y == 3'd6 ? "R6" : (y < 3'd4 ? "R3" : "R4"));
      end
      2'd1: begin
        e.flg = {~d[y], 1'b0, 1'b1, c, 4'h0};
        e.wr  = 1'b0;
        e.tag = "R7";
      end
      2'd2: begin
        r = d & ~(8'h01 << y);
        e.flg = {f[7:4], 4'h0};
        e.tag = "R8";
      end
      default: begin
        r = d | (8'h01 << y);
        e.flg = {f[7:4], 4'h0};
        e.tag = "R8";
      end
    endcase
    e.val = r;
    return e;
  endfunction

  task automatic drive(input logic acc, input logic [7:0] op,
                       input logic [7:0] d, input logic [7:0] f);
    @(negedge clk);
    acc_mode = acc; op_code = op; operand = d; flags_in = f;
    in_valid = 1'b1;
    sb.push_back(model(acc, op, d, f));
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor: outputs are due one clock after the request edge
  always @(negedge clk) begin
    if (!rst && !done && out_valid) begin
      if (sb.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2 actual=pulse expected=none");
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk({e.tag, " result"}, result, e.val);
        chk({e.tag, "/R5/R11 flags"}, flags_out, e.flg);
        chk({e.tag, " wr_en"}, {7'd0, wr_en}, {7'd0, e.wr});
        chk("R10 cycles", {5'd0, cycles}, {5'd0, e.cyc});
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 out_valid", {7'd0, out_valid}, 8'h00);
    chk("R1 result", result, 8'h00);
    chk("R1 flags", flags_out, 8'h00);
    chk("R1 cycles", {5'd0, cycles}, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after", {7'd0, out_valid}, 8'h00);

    // R3 R4 R5 R6: all kinds, several operands, both carry values, reg and mem
    foreach (sb[i]) ;
    for (int k = 0; k < 8; k++) begin
      for (int p = 0; p < 5; p++) begin
        logic [7:0] d;
        d = (p == 0) ? 8'h80 : (p == 1) ? 8'h01 : (p == 2) ? 8'h00 :
            (p == 3) ? 8'hA5 : 8'h3C;
        drive(1'b0, {2'd0, 3'(k), 3'(p == 4 ? 6 : 1)}, d, 8'h0F);
        drive(1'b0, {2'd0, 3'(k), 3'd6}, d, 8'hFF);
      end
    end
    // R7: bit test on every bit, zero and set bits, carry both ways
    for (int b = 0; b < 8; b++) begin
      drive(1'b0, {2'd1, 3'(b), 3'd2}, 8'h55, 8'h10);
      drive(1'b0, {2'd1, 3'(b), 3'd6}, 8'h55, 8'h00);
      drive(1'b0, {2'd2, 3'(b), 3'd0}, 8'hFF, 8'hA7);
      drive(1'b0, {2'd3, 3'(b), 3'd6}, 8'h00, 8'h5F);
    end
    // R9: accumulator rotates, zero result keeps Z clear; bit 5 of op ignored
    for (int k = 0; k < 4; k++) begin
      drive(1'b1, {3'd0, 2'(k), 3'd7}, 8'h00, 8'h00);
      drive(1'b1, {3'd0, 2'(k), 3'd7}, 8'h81, 8'h10);
      drive(1'b1, {3'd1, 2'(k), 3'd6}, 8'h80, 8'hF0);
    end
    // R2: back-to-back requests
    @(negedge clk);
    acc_mode = 1'b0; op_code = 8'h37; operand = 8'h12; flags_in = 8'h00;
    in_valid = 1'b1; sb.push_back(model(1'b0, 8'h37, 8'h12, 8'h00));
    @(negedge clk);
    op_code = 8'hFE; operand = 8'h00; flags_in = 8'h30;
    sb.push_back(model(1'b0, 8'hFE, 8'h00, 8'h30));
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R2 actual=%0d pending expected=0", sb.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule